// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls one bank of general-purpose pins behind a small register port. For each pin it decides whether the pin belongs to the GPIO function or to one of two on-chip peripheral functions, called A and B. For each pin it also holds the direction, the output data, the pull-up request and an open-drain option. It synchronises the pad inputs, can pass them through a glitch filter, and records a change on any pin, rising or falling, as a pending interrupt. The single interrupt output is high while any pending change is also unmasked.

No control bit is written directly. Each per-pin control has a set register and a clear register: a 1 in a written word acts on that pin, and a 0 leaves the pin alone. A third register reads the control back. The register port is a request stream and a response stream, each with valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. Only reads return a response. `req_ready` is low while a read response is waiting and `rsp_ready` is low, so there is at most one read in flight. A response holds its data until the consumer takes it.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, every pin is in GPIO mode, as an input, with pull-up requested. Interrupts are masked, the filter is off, open-drain is off and peripheral A is selected. `irq` is 0 and `pad_oe` is all zeros.
- R2: Word address 3k sets control k and 3k+1 clears it, for each 1 bit in the written data. Zero bits leave their pins unchanged. Address 3k+2 reads control k back. Controls k are: 0 GPIO ownership, 1 output enable, 2 output data, 3 pull-up, 4 glitch filter, 5 open-drain, 6 peripheral-B select, 7 interrupt mask.
- R3: Output data changes only through its set (address 6) and clear (address 7) registers, and reads back at address 8.
- R4: For a pin in GPIO mode, `pad_oe` follows the output-enable bit and `pad_out` follows the data bit. `pad_pullup` follows the pull-up control for every pin.
- R5: For a pin given to a peripheral, its B-select bit picks the B inputs (1) or the A inputs (0) to drive `pad_out` and `pad_oe`. Address 18 selects B, address 19 selects A, and address 20 reads the selection (0=A, 1=B).
- R6: Address 24 returns the synchronised level of every pad, whatever its mode. `periph_in` carries the same levels.
- R7: Any change of a pin's level, rising or falling, sets its pending bit. Reading address 25 returns the pending bits and clears them in the same cycle, while keeping any change that arrives in that cycle. The pad levels present at reset leave nothing pending.
- R8: `irq` is high exactly when some pending bit is also set in the interrupt mask.
- R9: With open-drain on, a pin drives low for data 0 and releases the pad (`pad_oe`=0) for data 1.
- R10: With the filter on, a pad pulse lasting one clock is ignored, and a pulse of two clocks gets through. With the filter off, a one-clock pulse is seen.
- R11: `req_ready` is `!rsp_valid || rsp_ready`. A response waiting under back-pressure keeps its data. Writes give no response. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bank clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | register request valid |
| req_ready | output | 1 | register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | word address |
| req_wdata | input | 32 | write data, one bit per pin |
| rsp_valid | output | 1 | read response valid |
| rsp_ready | input | 1 | read response ready |
| rsp_rdata | output | 32 | read response data |
| pad_in | input | 32 | pad input levels |
| pad_out | output | 32 | pad output data |
| pad_oe | output | 32 | pad output enable |
| pad_pullup | output | 32 | pull-up request |
| pa_out | input | 32 | peripheral A output data |
| pa_oe | input | 32 | peripheral A output enable |
| pb_out | input | 32 | peripheral B output data |
| pb_oe | input | 32 | peripheral B output enable |
| periph_in | output | 32 | synchronised pad levels to peripherals |
| irq | output | 1 | combined interrupt |

## Verification
The control registers get random set and clear words, so set bits, cleared bits and untouched bits appear together in the same word. After each write, the pad outputs are compared against a model built from random peripheral A/B drive values. This separates GPIO ownership, A/B selection and open-drain from one another. The interrupt path gets random pad words under random masks, which catches a missed edge direction, a missed clear-on-read and a wrong mask. Directed single-clock and two-clock pulses, with the filter on and off, check the filter's threshold. A response stalled by back-pressure checks that the data holds.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NCTL   = 8;
  localparam int C_GPIO = 0;
  localparam int C_OE   = 1;
  localparam int C_DOUT = 2;
  localparam int C_PULL = 3;
  localparam int C_FILT = 4;
  localparam int C_ODRN = 5;
  localparam int C_BSEL = 6;
  localparam int C_IMSK = 7;

  function automatic int adr_set(int k);
    return 3 * k;
  endfunction
  function automatic int adr_clr(int k);
    return 3 * k + 1;
  endfunction
  function automatic int adr_stat(int k);
    return 3 * k + 2;
  endfunction

  localparam int ADR_LEVEL = 3 * NCTL;
  localparam int ADR_PEND  = 3 * NCTL + 1;

  // reset value of every bit of control k
  function automatic logic ctl_rst(int k);
    return (k == C_GPIO) || (k == C_PULL);
  endfunction
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [NPINS-1:0]            wr_data,
  output logic [NCTL-1:0][NPINS-1:0]  ctl_q
);
  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(adr_set(k));
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(adr_clr(k));
    localparam logic              RV    = ctl_rst(k);
    logic [NPINS-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= {NPINS{RV}};
      else if (wr_en && wr_addr == A_SET) q <= q | wr_data;
      else if (wr_en && wr_addr == A_CLR) q <= q & ~wr_data;
    end

    assign ctl_q[k] = q;
  end
endmodule

// File: rtl/gpio_bank_infilt.sv
module gpio_bank_infilt #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] filt_en,
  output logic [NPINS-1:0] level
);
  logic [NPINS-1:0] s1_q, s2_q, samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      samp_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      samp_q <= s2_q;
    end
  end

  // filtered pins take a new value only after two equal samples
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic lv_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lv_q <= 1'b0;
      else if (!filt_en[i])         lv_q <= s2_q[i];
      else if (s2_q[i] == samp_q[i]) lv_q <= s2_q[i];
    end
    assign level[i] = lv_q;
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPINS    = 32,
  parameter int WARM_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] level,
  input  logic             rd_clr,
  output logic [NPINS-1:0] pend_q
);
  localparam int WW = $clog2(WARM_CYC + 1);
  localparam logic [WW-1:0] WARM_END = WW'(WARM_CYC);

  logic [WW-1:0]    warm_q;
  logic [NPINS-1:0] lvl_q;
  logic             armed;
  logic [NPINS-1:0] chg;

  assign armed = (warm_q == WARM_END);
  assign chg   = armed ? (level ^ lvl_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      if (!armed) warm_q <= warm_q + 1'b1;
      lvl_q  <= level;
      pend_q <= (rd_clr ? '0 : pend_q) | chg;
    end
  end
endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] gpio_own,
  input  logic [NPINS-1:0] oe,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] bsel,
  input  logic [NPINS-1:0] odrn,
  input  logic [NPINS-1:0] pa_out,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pb_out,
  input  logic [NPINS-1:0] pb_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic [NPINS-1:0] per_out, per_oe, eff_out, eff_oe;

  always_comb begin
    per_out = (bsel & pb_out) | (~bsel & pa_out);
    per_oe  = (bsel & pb_oe)  | (~bsel & pa_oe);
    eff_out = (gpio_own & dout) | (~gpio_own & per_out);
    eff_oe  = (gpio_own & oe)   | (~gpio_own & per_oe);
    pad_oe  = eff_oe & ~(odrn & eff_out);
    pad_out = eff_out & ~odrn;
  end
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPINS-1:0]  rsp_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pullup,
  input  logic [NPINS-1:0]  pa_out,
  input  logic [NPINS-1:0]  pa_oe,
  input  logic [NPINS-1:0]  pb_out,
  input  logic [NPINS-1:0]  pb_oe,
  output logic [NPINS-1:0]  periph_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(ADR_LEVEL);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(ADR_PEND);

  logic                       acc, wr_acc, rd_acc, pend_clr;
  logic [NCTL-1:0][NPINS-1:0] ctl_q;
  logic [NPINS-1:0]           level, pend_q, rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign pend_clr  = rd_acc && (req_addr == A_PEND);

  gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .wr_addr(req_addr),
    .wr_data(req_wdata), .ctl_q(ctl_q)
  );

  gpio_bank_infilt #(.NPINS(NPINS)) u_filt (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .filt_en(ctl_q[C_FILT]),
    .level(level)
  );

  gpio_bank_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .level(level), .rd_clr(pend_clr),
    .pend_q(pend_q)
  );

  gpio_bank_padmux #(.NPINS(NPINS)) u_mux (
    .gpio_own(ctl_q[C_GPIO]), .oe(ctl_q[C_OE]), .dout(ctl_q[C_DOUT]),
    .bsel(ctl_q[C_BSEL]), .odrn(ctl_q[C_ODRN]),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pad_pullup = ctl_q[C_PULL];
  assign periph_in  = level;
  assign irq        = |(pend_q & ctl_q[C_IMSK]);

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NCTL; k++)
      if (req_addr == ADDR_W'(adr_stat(k))) rd_mux = ctl_q[k];
    if (req_addr == A_LEVEL) rd_mux = level;
    if (req_addr == A_PEND)  rd_mux = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bank_ctl_chk.sv
module gpio_bank_ctl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [NPINS-1:0]           req_wdata,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [NPINS-1:0]           rsp_rdata,
  input logic [NPINS-1:0]           pad_out,
  input logic [NPINS-1:0]           pad_oe,
  input logic                       irq,
  input logic [NCTL-1:0][NPINS-1:0] ctl_q,
  input logic [NPINS-1:0]           pend_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == ADDR_W'(adr_set(C_OE))) |=>
      (((ctl_q[C_OE] & $past(req_wdata)) == $past(req_wdata)) &&
       ((ctl_q[C_OE] & ~$past(req_wdata)) == ($past(ctl_q[C_OE]) & ~$past(req_wdata)))));

  assert_clr_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == ADDR_W'(adr_clr(C_OE))) |=>
      ((ctl_q[C_OE] & $past(req_wdata)) == '0));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[C_IMSK] == '0) |-> !irq);

  assert_odrn_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q[C_ODRN] & pad_oe & pad_out) == '0));

  assert_pend_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == ADDR_W'(ADR_PEND)) |=>
      (rsp_valid && rsp_rdata == $past(pend_q)));
endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .ctl_q(ctl_q), .pend_q(pend_q)
);

// File: tb/gpio_bank_ctl_test.sv
module gpio_bank_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, pad_in = '1;
  logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata, pad_out, pad_oe, pad_pullup, periph_in;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] sh [8];

  always #10 clk = ~clk;

  gpio_bank_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .periph_in(periph_in), .irq(irq)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'(a);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    chk(rsp_valid == 1'b1, "R11 read response", 32'(rsp_valid), 32'd1);
  endtask

  function automatic logic [31:0] m_out();
    logic [31:0] po = (sh[6] & pb_out) | (~sh[6] & pa_out);
    logic [31:0] eo = (sh[0] & sh[2]) | (~sh[0] & po);
    return eo & ~sh[5];
  endfunction
  function automatic logic [31:0] m_oe();
    logic [31:0] po = (sh[6] & pb_out) | (~sh[6] & pa_out);
    logic [31:0] pe = (sh[6] & pb_oe) | (~sh[6] & pa_oe);
    logic [31:0] eo = (sh[0] & sh[2]) | (~sh[0] & po);
    logic [31:0] ee = (sh[0] & sh[1]) | (~sh[0] & pe);
    return ee & ~(sh[5] & eo);
  endfunction

  task automatic pulse0(input int cyc);
    @(negedge clk); pad_in[0] = ~pad_in[0];
    repeat (cyc) @(negedge clk);
    pad_in[0] = ~pad_in[0];
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, old, nw, m;
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) sh[k] = (k == 0 || k == 3) ? '1 : '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(pad_oe == '0, "R1 pad_oe", pad_oe, 0);
    chk(pad_pullup == '1, "R1 pullup", pad_pullup, '1);
    for (int k = 0; k < 8; k++) begin
      rd(3 * k + 2, d);
      chk(d == sh[k], "R1 control reset", d, sh[k]);
    end
    rd(25, d);
    chk(d == '0, "R7 nothing pending after reset", d, 0);

    // R2 zero bits leave state alone
    wr(3, 32'h0);
    rd(5, d);
    chk(d == sh[1], "R2 zero write", d, sh[1]);

    // random control writes (R2 R3 R4 R5 R9)
    for (int it = 0; it < 80; it++) begin
      int k = int'($urandom_range(7, 0));
      bit setw = 1'($urandom);
      logic [31:0] v = $urandom;
      if (k == 4) k = 5;
      pa_out = $urandom; pa_oe = $urandom; pb_out = $urandom; pb_oe = $urandom;
      wr(setw ? 3 * k : 3 * k + 1, v);
      sh[k] = setw ? (sh[k] | v) : (sh[k] & ~v);
      rd(3 * k + 2, d);
      chk(d == sh[k], k == 2 ? "R3 data set/clear" : (k == 6 ? "R5 select status" : "R2 set/clear"), d, sh[k]);
      chk(pad_out == m_out(), "R4 R5 R9 pad_out", pad_out, m_out());
      chk(pad_oe == m_oe(), "R4 R5 R9 pad_oe", pad_oe, m_oe());
      chk(pad_pullup == sh[3], "R4 pullup", pad_pullup, sh[3]);
    end

    // R9 directed open-drain
    wr(0, '1); sh[0] = '1;
    wr(3, 32'h3); sh[1] |= 32'h3;
    wr(15, 32'h3); sh[5] |= 32'h3;
    wr(6, 32'h1); wr(7, 32'h2); sh[2] = (sh[2] | 1) & ~32'h2;
    @(negedge clk);
    chk(pad_oe[1:0] == 2'b10, "R9 open-drain oe", 32'(pad_oe[1:0]), 2);
    chk(pad_out[1:0] == 2'b00, "R9 open-drain out", 32'(pad_out[1:0]), 0);

    // R6 level readback in peripheral mode
    wr(13, '1); wr(1, '1); sh[0] = '0;
    for (int it = 0; it < 4; it++) begin
      pad_in = $urandom;
      repeat (5) @(negedge clk);
      rd(24, d);
      chk(d == pad_in, "R6 level", d, pad_in);
      chk(periph_in == pad_in, "R6 periph_in", periph_in, pad_in);
    end

    // R7 R8 random changes and masks
    rd(25, d);
    for (int it = 0; it < 20; it++) begin
      m = $urandom;
      wr(22, ~m); wr(21, m);
      old = pad_in; nw = $urandom; pad_in = nw;
      repeat (6) @(negedge clk);
      chk(irq == |((old ^ nw) & m), "R8 irq", 32'(irq), 32'(|((old ^ nw) & m)));
      rd(25, d);
      chk(d == (old ^ nw), "R7 pending", d, old ^ nw);
      rd(25, d);
      chk(d == '0, "R7 cleared by read", d, 0);
      chk(irq == 1'b0, "R8 irq after clear", 32'(irq), 0);
    end
    // a pin that rises and falls again stays pending
    @(negedge clk); pad_in[3] = ~pad_in[3];
    repeat (3) @(negedge clk); pad_in[3] = ~pad_in[3];
    repeat (6) @(negedge clk);
    rd(25, d);
    chk(d == 32'h8, "R7 both edges", d, 32'h8);

    // R10 filter threshold
    pulse0(1); rd(25, d);
    chk(d == 32'h1, "R10 filter off sees pulse", d, 1);
    wr(12, 32'h1);
    pulse0(1); rd(25, d);
    chk(d == 32'h0, "R10 filter rejects pulse", d, 0);
    pulse0(2); rd(25, d);
    chk(d == 32'h1, "R10 filter passes two clocks", d, 1);

    // R11 back-pressure, unused address, writes without response
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 5'd5;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 ready low", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_rdata == sh[1], "R11 held response", rsp_rdata, sh[1]);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 taken", 32'(rsp_valid), 0);
    rd(30, d);
    chk(d == '0, "R11 unused address", d, 0);
    wr(14, 32'h0);
    chk(rsp_valid == 1'b0, "R11 write no response", 32'(rsp_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule